// File: doc/BRIEF.md
# Direct-Mapped Write-Back Block Cache

The block is a data cache between a processor's single-word port and a slower memory that moves one whole four-word block per transfer. It is direct mapped. The incoming address is cut into four fields: a tag, a line index, a word select and a byte offset. The line's valid bit and stored tag decide whether the access hits. A hit is answered in the same cycle the request is presented. A write hit changes only the cached word and marks the line dirty.

On a miss the controller first looks at the victim line. If the victim is valid and dirty, the whole old block is written to memory. The missing block is then fetched in full and installed as a clean line. After that the controller returns to lookup, where the held request is replayed and now hits. A write miss therefore allocates the line first and merges the word into it during the replay. The processor must keep its request, address, write enable and write data steady until it sees ready.

Top module: `wb_dm_cache`

## Requirements
- R1: After reset every line is invalid and the memory request is low. The first access to any block is not answered in its first cycle.
- R2: Accesses are whole 32-bit words with address bits [1:0] equal to zero. Bits [3:2] select the word within the block. The next log2(LINES) bits select the line (block address modulo LINES), and every higher bit is the tag.
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. A hit raises ready in the same cycle as the request. For a read hit, the read data in that cycle is the current value of the addressed word.
- R4: A write hit updates only the cached word and makes the line dirty. It causes no memory transaction.
- R5: A miss on an invalid or clean line starts no memory write. It issues exactly one block read at address {tag, index, 4'b0000}.
- R6: A miss on a valid dirty line first writes the whole victim block to address {old tag, index, 4'b0000}. Only after that write is acknowledged does it issue the block read for the new address.
- R7: A refill installs all four words of the block. Once the replayed access completes, the other three words of that block hit.
- R8: A write miss allocates. The block is refilled, the word is merged during the replay, and the line is dirty. A later eviction of that line writes the merged word to memory.
- R9: Ready is asserted only in a lookup cycle that hits, never while a memory request is open. The memory request, direction and address stay steady until acknowledged.
- R10: An acknowledge in the same cycle the memory request is raised is accepted. Back-to-back writeback and refill then take one cycle each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while ready is high |
| cpu_ready | output | 1 | Access completes at the next clock edge |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = block write (writeback), 0 = block read (refill) |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | 128 | Block being written back, word 0 in bits [31:0] |
| mem_rdata | input | 128 | Refill block, word 0 in bits [31:0] |
| mem_ack | input | 1 | Transfer completes at the next clock edge |

## Verification
The two functions that can share a cycle are the memory acknowledge and the state change that raises the memory request. With a zero-latency memory, the writeback acknowledge arrives in the first EVICT cycle and the refill acknowledge in the first FILL cycle. The bench provokes this by setting the memory latency to zero for the ping-pong sequence between two blocks that share a line, and for part of the random mix. It judges the result by the exact address and content of each block written to memory, the order of writeback and refill within one access, and read-back values checked against an arithmetic model of memory.

// File: rtl/wb_dm_cache_pkg.sv
package wb_dm_cache_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int BYTE_OFF_W = 2;
    localparam int WSEL_W     = 2;
    localparam int WORDS      = 1 << WSEL_W;
    localparam int LINE_W     = WORD_W * WORDS;
    localparam int LINE_OFF_W = WSEL_W + BYTE_OFF_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WSEL_W-1:0] wsel_t;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_FILL   = 2'd2
    } fsm_state_t;

    typedef struct packed {
        logic req;
        logic we;
    } mem_cmd_t;

    function automatic word_t pick_word(line_t line, wsel_t sel);
        return line[sel*WORD_W +: WORD_W];
    endfunction

endpackage

// File: rtl/wb_dm_cache_tags.sv
module wb_dm_cache_tags
    import wb_dm_cache_pkg::*;
#(
    parameter int LINES = 256,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= fill_tag;
        end
    end

    always_comb begin
        rd_valid = valid_q[idx];
        rd_dirty = dirty_q[idx];
        rd_tag   = tag_q[idx];
    end

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0 && dirty_q == '0));

    assert_fill_mark_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(fill_en && mark_dirty));

endmodule

// File: rtl/wb_dm_cache_data.sv
module wb_dm_cache_data
    import wb_dm_cache_pkg::*;
#(
    parameter int LINES = 256,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  line_t            fill_line,
    input  logic             word_we,
    input  wsel_t            word_sel,
    input  word_t            word_wdata,
    output line_t            rd_line
);

    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        word_t lane_q [LINES];

        always_ff @(posedge clk) begin
            if (fill_en) begin
                lane_q[idx] <= fill_line[w*WORD_W +: WORD_W];
            end else if (word_we && word_sel == wsel_t'(w)) begin
                lane_q[idx] <= word_wdata;
            end
        end

        assign rd_line[w*WORD_W +: WORD_W] = lane_q[idx];
    end

endmodule

// File: rtl/wb_dm_cache_fsm.sv
module wb_dm_cache_fsm
    import wb_dm_cache_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_req,
    input  logic       hit,
    input  logic       victim_dirty,
    input  logic       mem_ack,
    output fsm_state_t state,
    output mem_cmd_t   cmd,
    output logic       fill_en
);

    fsm_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOOKUP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cmd     = '{req: 1'b0, we: 1'b0};
        fill_en = 1'b0;
        case (state_q)
            ST_LOOKUP: begin
                if (cpu_req && !hit) begin
                    state_d = victim_dirty ? ST_EVICT : ST_FILL;
                end
            end
            ST_EVICT: begin
                cmd = '{req: 1'b1, we: 1'b1};
                if (mem_ack) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                cmd     = '{req: 1'b1, we: 1'b0};
                fill_en = mem_ack;
                if (mem_ack) begin
                    state_d = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    assign state = state_q;

    assert_memreq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd.req && !mem_ack) |=> (cmd.req && $stable(cmd.we)));

    assert_evict_then_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVICT && mem_ack) |=> (state_q == ST_FILL));

    assert_fill_returns_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && mem_ack) |=> (state_q == ST_LOOKUP && !cmd.req));

endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache
    import wb_dm_cache_pkg::*;
#(
    parameter int LINES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [127:0]      mem_wdata,
    input  logic [127:0]      mem_rdata,
    input  logic              mem_ack
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - LINE_OFF_W;

    logic [TAG_W-1:0] a_tag;
    logic [IDX_W-1:0] a_idx;
    wsel_t            a_wsel;

    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx  = cpu_addr[LINE_OFF_W +: IDX_W];
    assign a_wsel = cpu_addr[BYTE_OFF_W +: WSEL_W];

    logic             rd_valid, rd_dirty;
    logic [TAG_W-1:0] rd_tag;
    line_t            rd_line;
    logic             hit;
    logic             fill_en;
    logic             write_hit;
    fsm_state_t       state;
    mem_cmd_t         cmd;

    assign hit       = rd_valid && (rd_tag == a_tag);
    assign cpu_ready = cpu_req && (state == ST_LOOKUP) && hit;
    assign write_hit = cpu_ready && cpu_we;

    wb_dm_cache_tags #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
        .clk        (clk),
        .rst        (rst),
        .idx        (a_idx),
        .fill_en    (fill_en),
        .fill_tag   (a_tag),
        .mark_dirty (write_hit),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .rd_tag     (rd_tag)
    );

    wb_dm_cache_data #(.LINES(LINES)) i_data (
        .clk        (clk),
        .idx        (a_idx),
        .fill_en    (fill_en),
        .fill_line  (mem_rdata),
        .word_we    (write_hit),
        .word_sel   (a_wsel),
        .word_wdata (cpu_wdata),
        .rd_line    (rd_line)
    );

    wb_dm_cache_fsm i_fsm (
        .clk          (clk),
        .rst          (rst),
        .cpu_req      (cpu_req),
        .hit          (hit),
        .victim_dirty (rd_valid && rd_dirty),
        .mem_ack      (mem_ack),
        .state        (state),
        .cmd          (cmd),
        .fill_en      (fill_en)
    );

    assign cpu_rdata = pick_word(rd_line, a_wsel);
    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = {(cmd.we ? rd_tag : a_tag), a_idx, {LINE_OFF_W{1'b0}}};
    assign mem_wdata = rd_line;

    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> (cpu_addr[BYTE_OFF_W-1:0] == '0));

    assert_ready_no_mem_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req);

    assert_memaddr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    assert_evict_only_dirty_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (rd_valid && rd_dirty));

    assert_replay_hits_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL && mem_ack && cpu_req) |=> cpu_ready);

endmodule

// File: tb/test_wb_dm_cache.sv
`timescale 1ns/1ps
module test_wb_dm_cache;

    localparam int NL = 8;      // small configuration: 8 lines, tag = addr[31:7]
    localparam int NB = 64;     // modelled memory: 64 blocks (1 KiB)

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wb_dm_cache #(.LINES(NL)) i_wb_dm_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] init_word(input int wa);
        return (wa * 32'h9E37_79B1) ^ 32'hC0DE_0000;
    endfunction

    // arithmetic memory and processor-view model
    logic [31:0] bmem [NB*4];
    logic [31:0] refw [NB*4];
    bit          mv [NL];
    bit          md [NL];
    int          mt [NL];

    // memory model state
    int  lat = 0;
    int  lat_cnt = 0;
    int  rd_cnt, wr_cnt;
    int  exp_wb_blk, exp_rd_blk;

    always @(negedge clk) begin
        if (!mem_req) begin
            mem_ack = 1'b0;
            lat_cnt = 0;
        end else if (lat_cnt >= lat) begin
            int blk;
            blk = int'(mem_addr[9:4]);
            mem_ack = 1'b1;
            lat_cnt = 0;
            chk(mem_addr[31:10] == 0 && mem_addr[3:0] == 0, "R2 block address alignment", mem_addr, {mem_addr[9:4], 4'b0});
            if (mem_we) begin
                wr_cnt++;
                chk(rd_cnt == 0, "R6 writeback precedes refill", rd_cnt, 0);
                chk(blk == exp_wb_blk, "R6 writeback address", blk, exp_wb_blk);
                for (int w = 0; w < 4; w++) begin
                    chk(mem_wdata[w*32 +: 32] == refw[blk*4+w], "R8 writeback block content",
                        mem_wdata[w*32 +: 32], refw[blk*4+w]);
                    bmem[blk*4+w] = mem_wdata[w*32 +: 32];
                end
            end else begin
                rd_cnt++;
                chk(blk == exp_rd_blk, "R5 refill address", blk, exp_rd_blk);
                for (int w = 0; w < 4; w++) mem_rdata[w*32 +: 32] = bmem[blk*4+w];
            end
        end else begin
            mem_ack = 1'b0;
            lat_cnt++;
        end
    end

    task automatic access(input bit we, input int wa, input logic [31:0] wd);
        int  blk, idx, t, waited;
        bit  exp_hit, exp_wb, first;
        logic [31:0] rd;
        blk = wa / 4; idx = blk % NL; t = blk / NL;
        exp_hit    = mv[idx] && mt[idx] == t;
        exp_wb     = !exp_hit && mv[idx] && md[idx];
        exp_wb_blk = mt[idx] * NL + idx;
        exp_rd_blk = blk;
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = wa * 4; cpu_wdata = wd;
        #1;
        first = cpu_ready;
        waited = 0;
        while (!cpu_ready && waited < 100) begin
            @(negedge clk); #1; waited++;
            if (cpu_ready == 1'b0 && mem_req == 1'b0 && waited > 3 && rd_cnt != 0)
                ; // replay pending
        end
        chk(cpu_ready, "R9 access completes", cpu_ready, 1);
        chk(!(cpu_ready && mem_req), "R9 ready with open memory request", mem_req, 0);
        rd = cpu_rdata;
        chk(first == exp_hit, exp_hit ? "R3 hit served in request cycle" : "R1 miss not answered at once", first, exp_hit);
        chk(wr_cnt == (exp_wb ? 1 : 0), exp_wb ? "R6 dirty victim written back" : "R4 no memory write", wr_cnt, exp_wb);
        chk(rd_cnt == (exp_hit ? 0 : 1), exp_hit ? "R4 hit makes no refill" : "R5 one refill per miss", rd_cnt, !exp_hit);
        if (!we) chk(rd == refw[wa], "R3 read data", rd, refw[wa]);
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        mv[idx] = 1'b1; mt[idx] = t;
        if (!exp_hit) md[idx] = 1'b0;
        if (we) begin md[idx] = 1'b1; refw[wa] = wd; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < NB*4; i++) begin bmem[i] = init_word(i); refw[i] = init_word(i); end
        for (int i = 0; i < NL; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1 reset state", {cpu_ready, mem_req}, 0);

        // R1 R5 R7: sequential sweep of all words, one miss per block, three hits
        for (int wa = 0; wa < NB*4; wa++) begin
            lat = (wa / 4) % 3;
            access(1'b0, wa, '0);
        end

        // R4 R6 R8: write every word of 16 blocks (two tags per line), then read back
        for (int wa = 0; wa < 64; wa++) begin
            lat = wa % 4;
            access(1'b1, wa, 32'h5A00_0000 + wa * 32'h0000_0101);
        end
        for (int wa = 0; wa < 64; wa++) begin
            lat = 1;
            access(1'b0, wa, '0);
        end

        // R10: ping-pong between blocks sharing line 0, zero-latency memory
        lat = 0;
        for (int k = 0; k < 40; k++) begin
            int wa;
            wa = ((k % 2) ? NL * 4 : 0) + (k % 4);
            access(k % 3 != 2, wa, 32'hD000_0000 + k);
        end

        // mixed pseudo-random traffic
        lf = 16'hACE1;
        for (int k = 0; k < 1500; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            lat = int'(lf[10:9]);
            access(lf[8], int'(lf[7:0]), {lf, ~lf});
        end

        // R8: read every word once more against the model
        lat = 0;
        for (int wa = 0; wa < NB*4; wa++) access(1'b0, wa, '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule